// File: doc/BRIEF.md
# Oversampled SPI Slave Port

This block is the target side of a four-wire serial link. It runs wholly on the system clock. The serial clock, the select line and the data input are treated as ordinary data: each passes through a two-flop synchronizer, and edges of the serial clock are found by comparing successive samples. Because of this the serial clock may run at no more than a quarter of the system clock.

While select is high the port is idle. MISO is not driven, and serial clock edges do nothing. The host may write the next byte to send at any time. When select falls, that byte is loaded and its most significant bit is placed on MISO before the first clock edge. The link uses mode 0 with MSB first. MOSI is captured on each detected rising edge, and the next outgoing bit is presented after each detected falling edge. After eight rising edges the received byte moves into a read buffer, the done flag is set, and an interrupt is raised if it is enabled. If select rises in the middle of a byte, that partial byte is dropped.

Top module: `spi_sampled_slave`

## Requirements
- R1: While select is high, `miso_oe` is 0 and serial clock edges change neither the bit count nor the done flag. A full transfer that follows such edges therefore still begins at bit 7.
- R2: A byte written with `tx_wr` while select is high is sent MSB first once select falls. Its bit 7 is on `miso_out` before the first rising serial clock edge.
- R3: In mode 0, MOSI is sampled on each detected rising serial clock edge, MSB first. After eight rising edges, `rx_data` holds the eight sampled bits, with the first bit in bit 7.
- R4: `done` is set when a byte completes and is cleared by a one-cycle `rx_rd` pulse. If completion and `rx_rd` fall in the same cycle, the set wins. `irq` equals `done` AND `irq_en`.
- R5: A byte written during a transfer is sent as the next byte in the same select period. It is loaded on the first falling edge after the current byte completes.
- R6: `rx_data` keeps the completed byte while the next one shifts in. It is overwritten only when the next byte completes, whether or not it was read.
- R7: If select rises before the eighth rising edge, the partial byte is dropped. `done` stays clear, `rx_data` keeps its value, and the next transfer starts at bit 7.
- R8: While selected, `miso_out` changes only after a detected falling serial clock edge or a select fall. Each input change takes effect on the third system clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Serial clock from the controller (asynchronous) |
| cs_n_in | input | 1 | Active-low select from the controller (asynchronous) |
| mosi_in | input | 1 | Serial data from the controller |
| miso_out | output | 1 | Serial data to the controller, valid when `miso_oe` is 1 |
| miso_oe | output | 1 | Output enable for the MISO pad |
| tx_wr | input | 1 | Strobe that writes `tx_data` into the transmit register |
| tx_data | input | W | Byte to send |
| rx_rd | input | 1 | Strobe that acknowledges the received byte and clears `done` |
| rx_data | output | W | Last fully received byte |
| irq_en | input | 1 | Interrupt enable |
| done | output | 1 | Transfer-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The main function is tried with the following patterns:
- An isolated byte, with the interrupt enabled and then disabled. This checks bit order and how the flag is gated.
- Clock pulses while the port is deselected, followed by a normal byte. A counter that wrongly advanced while idle would show up as a bit misalignment.
- Two bytes back to back under one select, with the second byte written mid-transfer and the first never read. This separates the single-buffered transmit path from the double-buffered receive path and shows the overwrite.
- A byte cut short by select rising, then a full byte. This shows that partial data never reaches the flag or the buffer and that the counter restarts.

// File: rtl/spi_sampled_slave.sv
module spi_sampled_slave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_in,
  input  logic         cs_n_in,
  input  logic         mosi_in,
  output logic         miso_out,
  output logic         miso_oe,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_data,
  input  logic         rx_rd,
  output logic [W-1:0] rx_data,
  input  logic         irq_en,
  output logic         done,
  output logic         irq
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    mosi_q;
  logic [W-1:0]  tx_reg, tx_sh, rx_sh, rx_buf;
  logic [CW-1:0] cnt;
  logic          flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_in};
      cs_q   <= {cs_q[1:0], cs_n_in};
      mosi_q <= {mosi_q[0], mosi_in};
    end
  end

  wire active   = !cs_q[1];
  wire cs_fall  = cs_q[2] && !cs_q[1];
  wire sck_rise = active && !cs_fall && sck_q[1] && !sck_q[2];
  wire sck_fall = active && !cs_fall && !sck_q[1] && sck_q[2];
  wire complete = sck_rise && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_reg <= '0;
    else if (tx_wr) tx_reg <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      cnt   <= '0;
    end else if (!active || cs_fall) begin
      cnt <= '0;
      if (cs_fall) tx_sh <= tx_reg;
    end else begin
      if (sck_rise) begin
        rx_sh <= {rx_sh[W-2:0], mosi_q[1]};
        cnt   <= complete ? '0 : cnt + 1'b1;
      end
      if (sck_fall) tx_sh <= (cnt == '0) ? tx_reg : {tx_sh[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0;
      flag   <= 1'b0;
    end else if (complete) begin
      rx_buf <= {rx_sh[W-2:0], mosi_q[1]};
      flag   <= 1'b1;
    end else if (rx_rd) begin
      flag   <= 1'b0;
    end
  end

  assign miso_oe  = active;
  assign miso_out = active ? tx_sh[W-1] : 1'b0;
  assign rx_data  = rx_buf;
  assign done     = flag;
  assign irq      = flag && irq_en;

  a_r1_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[1] |=> (cnt == '0));
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && cnt == LAST) |=> done);
  a_r6_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(rx_data));
  a_r7_no_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[1] |=> !$rose(done));
  a_r8_miso_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sck_fall && !cs_fall) |=> (!miso_oe || $stable(miso_out)));
endmodule

// File: tb/spi_sampled_slave_bench.sv
module spi_sampled_slave_bench;
  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0, tx_wr = 0, rx_rd = 0, irq_en = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic miso_out, miso_oe, done, irq;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  spi_sampled_slave u_spi_sampled_slave (
    .clk(clk), .rst_n(rst_n), .sck_in(sck), .cs_n_in(cs_n), .mosi_in(mosi),
    .miso_out(miso_out), .miso_oe(miso_oe), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .irq_en(irq_en), .done(done), .irq(irq));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] b);
    tx_data = b; tx_wr = 1; wait_clk(1); tx_wr = 0;
  endtask

  task automatic read_rx();
    rx_rd = 1; wait_clk(1); rx_rd = 0;
  endtask

  task automatic select();
    cs_n = 0; wait_clk(6);
  endtask

  task automatic deselect();
    cs_n = 1; wait_clk(6);
  endtask

  task automatic shift_bits(input logic [7:0] m, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      got[i] = miso_out;
      mosi = m[i]; sck = 1; wait_clk(4);
      sck = 0; wait_clk(4);
    end
  endtask

  task automatic t_reset();
    check("R1 reset oe", miso_oe, 0);
    check("R4 reset done", done, 0);
    check("R4 reset irq", irq, 0);
    check("R6 reset rx", rx_data, 0);
  endtask

  task automatic t_idle();
    logic [7:0] got;
    mosi = 1;
    for (int k = 0; k < 3; k++) begin sck = 1; wait_clk(4); sck = 0; wait_clk(4); end
    check("R1 idle oe", miso_oe, 0);
    check("R1 idle done", done, 0);
    check("R1 idle rx", rx_data, 0);
    load_tx(8'hA5);
    select();
    check("R1 oe selected", miso_oe, 1);
    check("R2 msb before edge", miso_out, 1);
    shift_bits(8'h3C, 8, got);
    check("R1 rx after idle edges", rx_data, 8'h3C);
    check("R2 miso bits", got, 8'hA5);
    deselect();
    read_rx();
  endtask

  task automatic t_irq();
    logic [7:0] got;
    irq_en = 1;
    load_tx(8'h81);
    select();
    shift_bits(8'hC3, 8, got);
    check("R3 rx byte", rx_data, 8'hC3);
    check("R2 tx byte", got, 8'h81);
    check("R4 done set", done, 1);
    check("R4 irq on", irq, 1);
    deselect();
    read_rx();
    check("R4 done cleared", done, 0);
    check("R4 irq cleared", irq, 0);
    irq_en = 0;
    select();
    shift_bits(8'h5A, 8, got);
    check("R4 done no irq", done, 1);
    check("R4 irq gated", irq, 0);
    check("R3 rx second", rx_data, 8'h5A);
    deselect();
    read_rx();
  endtask

  task automatic t_back_to_back();
    logic [7:0] got;
    load_tx(8'hF0);
    select();
    shift_bits(8'h12, 4, got);
    load_tx(8'h69);
    shift_bits(8'h12 << 4, 4, got);
    check("R6 first byte", rx_data, 8'h12);
    shift_bits(8'h34, 4, got);
    check("R6 held mid next", rx_data, 8'h12);
    check("R5 next tx high nibble", got[7:4], 4'h6);
    shift_bits(8'h34 << 4, 4, got);
    check("R5 next tx low nibble", got[7:4], 4'h9);
    check("R6 overwritten", rx_data, 8'h34);
    deselect();
    read_rx();
  endtask

  task automatic t_abort();
    logic [7:0] got;
    logic q0, q1;
    load_tx(8'hC6);
    select();
    shift_bits(8'hFF, 4, got);
    deselect();
    check("R7 no flag", done, 0);
    check("R7 rx kept", rx_data, 8'h34);
    select();
    q0 = miso_out;
    wait_clk(2);
    q1 = miso_out;
    check("R8 miso steady", q1, q0);
    shift_bits(8'h96, 8, got);
    check("R7 restart rx", rx_data, 8'h96);
    check("R7 restart tx", got, 8'hC6);
    deselect();
    check("R8 oe off", miso_oe, 0);
  endtask

  initial begin
    fork
      begin
        wait_clk(3); rst_n = 1; wait_clk(2);
        t_reset();
        t_idle();
        t_irq();
        t_back_to_back();
        t_abort();
      end
      begin
        wait_clk(50000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule